// File: doc/BRIEF.md
# LIN Break and Sync Auto-Baud Detector

This block watches an already-synchronised serial receive line for a long low pulse (a break). It then times the alternating sync character that follows and turns the measured bit time into a new baud divisor. The divisor is published with a one-cycle strobe only when it falls inside the legal divisor range. In the strict LIN-style auto mode the sync character must also have the expected shape. A sticky break flag reports a completed break-plus-sync, and a sticky error flag reports a sync that could not be accepted.

The mode input selects one of four receive modes: 2'b00 plain, 2'b01 double-speed, 2'b10 LIN-auto and 2'b11 generic-auto. Detection runs only in the two auto modes. The break threshold is 11 bit times at the divisor currently presented on `baud_div_i`, where one bit time equals `baud_div_i` clocks. A one-shot wait request lifts that threshold for the next low pulse. Receiving the data byte after the sync is left to a neighbouring receiver, which reports each received byte on `data_rcvd_i`.

Top module: `lin_sync_detect`

## Requirements
- R1: In an auto mode, a low pulse of L clocks on `rxd_i` is taken as a break only if L >= 11 * `baud_div_i`. Shorter pulses are discarded, and no sync measurement follows them.
- R2: A one-cycle `wfb_req_i` arms a pending request. The next low pulse then counts as a break whatever its width. The request is used up by that pulse, so a later short pulse is rejected again.
- R3: After a break, the sync character is timed from its start-bit falling edge to the 8th following transition. Call this span S clocks. The result, divisor = (S + 4) / 8 rounded down, appears on `baud_div_o` together with a `baud_vld_o` pulse exactly one cycle wide.
- R4: If the computed divisor is below DIV_MIN or above DIV_MAX, no strobe is issued and `sync_err_o` sets. A sync still running after 8*DIV_MAX+3 clocks is aborted with the same error.
- R5: In LIN-auto mode, the span between the longest and the shortest of the 8 transition intervals must not exceed S/16 (rounded down), or `sync_err_o` sets. A character other than 0x55 never produces 8 transitions before its stop bit, so it ends in the R4 timeout error.
- R6: In generic-auto mode, the interval-spread check of R5 is skipped and only the range rules of R4 apply.
- R7: `brk_flag_o` rises in the same cycle as `baud_vld_o` and stays 0 while the break or the sync is still in progress.
- R8: `brk_flag_o` clears one cycle after a pulse on `data_rcvd_i` or on `brk_clr_i`.
- R9: In plain or double-speed mode, the detector is held idle. `brk_flag_o` and `sync_err_o` read 0 from the next cycle, and no strobe is issued.
- R10: After a sync error, the detector ignores `rxd_i` and `sync_err_o` holds. A `sync_err_clr_i` pulse clears the flag and re-arms break detection.
- R11: After reset, `brk_flag_o`, `sync_err_o` and `baud_vld_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Synchronised receive line, idle high |
| mode_i | input | 2 | 00 plain, 01 double-speed, 10 LIN-auto, 11 generic-auto |
| baud_div_i | input | DIV_W | Divisor in use, clocks per bit |
| wfb_req_i | input | 1 | One-shot request: next low pulse counts as a break |
| sync_err_clr_i | input | 1 | Clears the sync error and re-arms detection |
| brk_clr_i | input | 1 | Clears the break flag |
| data_rcvd_i | input | 1 | Pulse from the receiver when a data byte arrives |
| brk_flag_o | output | 1 | Break and valid sync seen |
| sync_err_o | output | 1 | Sync timing or shape rejected |
| baud_vld_o | output | 1 | One-cycle strobe for a new divisor |
| baud_div_o | output | DIV_W | Measured divisor, valid with the strobe |

## Verification
A corrupted low-pulse counter or threshold shows up at the ports within one pulse. A 219-clock low then produces a strobe, or a 220-clock low fails to produce one, at the end of the following sync. A fault in the interval trackers or the rounding changes `baud_div_o`, or flips the accept/error outcome, in the cycle right after the 8th sync transition. A stuck state shows up only later: the error flag fails to hold through a full break and sync, or a second sync still produces a strobe. Exact boundary divisors and a skewed-interval sync fed to both auto modes separate the range rule from the shape rule.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_DBL  = 2'b01,
    MODE_LIN  = 2'b10,
    MODE_GEN  = 2'b11
  } lsd_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_DELIM,
    ST_MEAS,
    ST_EVAL,
    ST_ERR
  } lsd_state_e;
endpackage

// File: rtl/lsd_edge.sv
module lsd_edge (
  input  logic clk,
  input  logic rst,
  input  logic rxd_i,
  output logic fall_o,
  output logic rise_o,
  output logic any_o
);
  logic rxd_q;

  always_ff @(posedge clk) begin
    if (rst) rxd_q <= 1'b1;
    else     rxd_q <= rxd_i;
  end

  assign fall_o = rxd_q & ~rxd_i;
  assign rise_o = ~rxd_q & rxd_i;
  assign any_o  = rxd_q ^ rxd_i;
endmodule

// File: rtl/lsd_meas.sv
module lsd_meas #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] ivl_min_o,
  output logic [CNT_W-1:0] ivl_max_o
);
  logic [CNT_W-1:0] ivl_q;
  logic [CNT_W-1:0] ivl_len;

  assign ivl_len = ivl_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      total_o   <= '0;
      ivl_q     <= '0;
      ivl_min_o <= '1;
      ivl_max_o <= '0;
    end else if (run_i) begin
      total_o <= total_o + 1'b1;
      if (edge_i) begin
        ivl_q <= '0;
        if (ivl_len < ivl_min_o) ivl_min_o <= ivl_len;
        if (ivl_len > ivl_max_o) ivl_max_o <= ivl_len;
      end else begin
        ivl_q <= ivl_len;
      end
    end
  end
endmodule

// File: rtl/lsd_eval.sv
module lsd_eval #(
  parameter int DIV_W   = 16,
  parameter int CNT_W   = 20,
  parameter int DIV_MIN = 16,
  parameter int DIV_MAX = 65535
) (
  input  logic [CNT_W-1:0] total_i,
  input  logic [CNT_W-1:0] ivl_min_i,
  input  logic [CNT_W-1:0] ivl_max_i,
  input  logic             shape_chk_i,
  output logic [DIV_W-1:0] div_o,
  output logic             bad_o
);
  logic [CNT_W-1:0] rnd;
  logic [CNT_W-1:0] per;
  logic [CNT_W-1:0] spread;
  logic [CNT_W-1:0] tol;
  logic             range_bad;
  logic             shape_bad;

  always_comb begin
    rnd       = total_i + CNT_W'(4);
    per       = rnd >> 3;
    spread    = ivl_max_i - ivl_min_i;
    tol       = total_i >> 4;
    range_bad = (per < CNT_W'(DIV_MIN)) || (per > CNT_W'(DIV_MAX));
    shape_bad = shape_chk_i && (spread > tol);
    bad_o     = range_bad || shape_bad;
    div_o     = per[DIV_W-1:0];
  end
endmodule

// File: rtl/lin_sync_detect.sv
module lin_sync_detect
  import lsd_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 16,
  parameter int DIV_MAX = 65535
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd_i,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             wfb_req_i,
  input  logic             sync_err_clr_i,
  input  logic             brk_clr_i,
  input  logic             data_rcvd_i,
  output logic             brk_flag_o,
  output logic             sync_err_o,
  output logic             baud_vld_o,
  output logic [DIV_W-1:0] baud_div_o
);
  localparam int CNT_W = DIV_W + 4;
  localparam logic [CNT_W-1:0] TMO_LIM = CNT_W'(8 * DIV_MAX + 3);

  lsd_state_e       state_q;
  logic             fall, rise, any_edge;
  logic             auto_en, lin_mode;
  logic             meas_start, meas_run;
  logic [CNT_W-1:0] total, ivl_min, ivl_max;
  logic [DIV_W-1:0] div_calc;
  logic             div_bad;
  logic [CNT_W-1:0] lo_cnt;
  logic [CNT_W:0]   lo_len;
  logic [CNT_W-1:0] bd_ext, thr;
  logic [2:0]       ecnt;
  logic             wfb_pend;
  logic             brk_ok;

  assign auto_en    = mode_i[1];
  assign lin_mode   = (lsd_mode_e'(mode_i) == MODE_LIN);
  assign meas_start = (state_q == ST_DELIM) && fall;
  assign meas_run   = (state_q == ST_MEAS);

  lsd_edge edge_i (
    .clk(clk), .rst(rst), .rxd_i(rxd_i),
    .fall_o(fall), .rise_o(rise), .any_o(any_edge)
  );

  lsd_meas #(.CNT_W(CNT_W)) meas_i (
    .clk(clk), .rst(rst), .start_i(meas_start), .run_i(meas_run),
    .edge_i(any_edge), .total_o(total), .ivl_min_o(ivl_min), .ivl_max_o(ivl_max)
  );

  lsd_eval #(.DIV_W(DIV_W), .CNT_W(CNT_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) eval_i (
    .total_i(total), .ivl_min_i(ivl_min), .ivl_max_i(ivl_max),
    .shape_chk_i(lin_mode), .div_o(div_calc), .bad_o(div_bad)
  );

  // Break threshold: 11 bit times at the divisor in use.
  assign bd_ext = CNT_W'(baud_div_i);
  assign thr    = (bd_ext << 3) + (bd_ext << 1) + bd_ext;
  assign lo_len = {1'b0, lo_cnt} + 1'b1;
  assign brk_ok = wfb_pend || (lo_len >= {1'b0, thr});

  always_ff @(posedge clk) begin
    if (rst) begin
      wfb_pend <= 1'b0;
    end else if (wfb_req_i) begin
      wfb_pend <= 1'b1;
    end else if (auto_en && state_q == ST_BRK && rise) begin
      wfb_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      lo_cnt     <= '0;
      ecnt       <= '0;
      brk_flag_o <= 1'b0;
      sync_err_o <= 1'b0;
      baud_vld_o <= 1'b0;
      baud_div_o <= '0;
    end else if (!auto_en) begin
      state_q    <= ST_IDLE;
      brk_flag_o <= 1'b0;
      sync_err_o <= 1'b0;
      baud_vld_o <= 1'b0;
    end else begin
      baud_vld_o <= 1'b0;
      if (data_rcvd_i || brk_clr_i) brk_flag_o <= 1'b0;
      if (sync_err_clr_i)           sync_err_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fall) begin
            state_q <= ST_BRK;
            lo_cnt  <= '0;
          end
        end
        ST_BRK: begin
          if (rise) state_q <= brk_ok ? ST_DELIM : ST_IDLE;
          else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
        end
        ST_DELIM: begin
          if (fall) begin
            state_q <= ST_MEAS;
            ecnt    <= '0;
          end
        end
        ST_MEAS: begin
          if (any_edge && ecnt == 3'd7) begin
            state_q <= ST_EVAL;
          end else if (total >= TMO_LIM) begin
            state_q    <= ST_ERR;
            sync_err_o <= 1'b1;
          end else if (any_edge) begin
            ecnt <= ecnt + 1'b1;
          end
        end
        ST_EVAL: begin
          if (div_bad) begin
            state_q    <= ST_ERR;
            sync_err_o <= 1'b1;
          end else begin
            state_q    <= ST_IDLE;
            baud_vld_o <= 1'b1;
            baud_div_o <= div_calc;
            brk_flag_o <= 1'b1;
          end
        end
        ST_ERR: begin
          if (sync_err_clr_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsd_chk.sv
module lsd_chk #(
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 16,
  parameter int DIV_MAX = 65535
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic             sync_err_clr_i,
  input logic             brk_flag_o,
  input logic             sync_err_o,
  input logic             baud_vld_o,
  input logic [DIV_W-1:0] baud_div_o
);
  // R3: the new-divisor strobe lasts one cycle
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    baud_vld_o |=> !baud_vld_o);

  // R4: a published divisor lies in the legal range
  a_r4_div_in_range: assert property (@(posedge clk) disable iff (rst)
    baud_vld_o |-> (baud_div_o >= DIV_W'(DIV_MIN) && baud_div_o <= DIV_W'(DIV_MAX)));

  // R7: the break flag only rises together with an accepted sync
  a_r7_flag_with_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_flag_o) |-> baud_vld_o);

  // R9: non-auto modes hold everything quiet
  a_r9_non_auto_quiet: assert property (@(posedge clk) disable iff (rst)
    !mode_i[1] |=> (!brk_flag_o && !sync_err_o && !baud_vld_o));

  // R10: the error flag holds until cleared
  a_r10_err_holds: assert property (@(posedge clk) disable iff (rst)
    (sync_err_o && !sync_err_clr_i && mode_i[1]) |=> sync_err_o);

  // R10: no strobe while an error is pending
  a_r10_no_strobe_in_err: assert property (@(posedge clk) disable iff (rst)
    sync_err_o |-> !baud_vld_o);
endmodule

bind lin_sync_detect lsd_chk #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) chk_i (
  .clk(clk), .rst(rst), .mode_i(mode_i), .sync_err_clr_i(sync_err_clr_i),
  .brk_flag_o(brk_flag_o), .sync_err_o(sync_err_o), .baud_vld_o(baud_vld_o),
  .baud_div_o(baud_div_o)
);

// File: tb/lin_sync_detect_tb.sv
`timescale 1ns/1ps
module lin_sync_detect_tb_top;
  localparam int DIV_W = 8;
  localparam int DMIN  = 4;
  localparam int DMAX  = 200;
  localparam int BDIV  = 20;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] base;
    logic [7:0] last;
    logic       err;
    logic [7:0] div;
  } vec_t;

  // mode, 7 equal intervals, final interval, error expected, divisor expected
  localparam vec_t VECS [10] = '{
    '{2'b10, 8'd20,  8'd20,  1'b0, 8'd20},   // R3 LIN nominal
    '{2'b10, 8'd37,  8'd37,  1'b0, 8'd37},   // R3
    '{2'b11, 8'd50,  8'd50,  1'b0, 8'd50},   // R3 generic
    '{2'b10, 8'd20,  8'd60,  1'b1, 8'd0},    // R5 skewed -> error
    '{2'b11, 8'd20,  8'd60,  1'b0, 8'd25},   // R6 skew ignored
    '{2'b10, 8'd3,   8'd3,   1'b1, 8'd0},    // R4 too fast
    '{2'b11, 8'd4,   8'd4,   1'b0, 8'd4},    // R4 min boundary
    '{2'b11, 8'd200, 8'd200, 1'b0, 8'd200},  // R4 max boundary
    '{2'b11, 8'd201, 8'd201, 1'b1, 8'd0},    // R4 too slow, timeout
    '{2'b10, 8'd36,  8'd44,  1'b0, 8'd37}    // R5 within tolerance
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic [1:0] mode = 2'b10;
  logic wfb = 1'b0, eclr = 1'b0, bclr = 1'b0, drcv = 1'b0;
  logic brk_flag, sync_err, baud_vld;
  logic [DIV_W-1:0] baud_div;

  int n_chk = 0;
  int n_bad = 0;
  int vld_cnt = 0;
  int last_div = 0;

  always #4 clk = ~clk;

  lin_sync_detect #(.DIV_W(DIV_W), .DIV_MIN(DMIN), .DIV_MAX(DMAX)) dut_i (
    .clk(clk), .rst(rst), .rxd_i(rxd), .mode_i(mode), .baud_div_i(DIV_W'(BDIV)),
    .wfb_req_i(wfb), .sync_err_clr_i(eclr), .brk_clr_i(bclr), .data_rcvd_i(drcv),
    .brk_flag_o(brk_flag), .sync_err_o(sync_err), .baud_vld_o(baud_vld),
    .baud_div_o(baud_div)
  );

  always @(negedge clk) begin
    if (!rst && baud_vld) begin
      vld_cnt  <= vld_cnt + 1;
      last_div <= int'(baud_div);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_break(input int clocks);
    hold(1'b0, clocks);
    hold(1'b1, 2 * BDIV);
  endtask

  task automatic send_ivls(input int b, input int l);
    hold(1'b0, b);
    for (int k = 1; k < 7; k++) hold(logic'(k % 2), b);
    hold(1'b1, l);
    hold(1'b0, b);
    hold(1'b1, 3 * b);
  endtask

  task automatic send_byte(input logic [7:0] d, input int t);
    hold(1'b0, t);
    for (int k = 0; k < 8; k++) hold(d[k], t);
    hold(1'b1, t);
  endtask

  task automatic clear_all();
    eclr = 1'b1; bclr = 1'b1;
    @(posedge clk); #1;
    eclr = 1'b0; bclr = 1'b0;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic good_sync();
    send_break(13 * BDIV);
    send_ivls(BDIV, BDIV);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R11 brk_flag after reset", int'(brk_flag), 0);
    chk("R11 sync_err after reset", int'(sync_err), 0);
    chk("R11 strobe after reset", int'(baud_vld), 0);
    @(posedge clk); #1;

    // Table walk
    for (int i = 0; i < 10; i++) begin
      int v0;
      v0 = vld_cnt;
      mode = VECS[i].mode;
      send_break(13 * BDIV);
      send_ivls(int'(VECS[i].base), int'(VECS[i].last));
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R3/R4/R5/R6 vec%0d strobe count", i), vld_cnt - v0, VECS[i].err ? 0 : 1);
      if (!VECS[i].err) chk($sformatf("R3 vec%0d divisor", i), last_div, int'(VECS[i].div));
      chk($sformatf("R4/R5 vec%0d sync_err", i), int'(sync_err), int'(VECS[i].err));
      chk($sformatf("R7 vec%0d brk_flag", i), int'(brk_flag), VECS[i].err ? 0 : 1);
      @(posedge clk); #1;
      clear_all();
    end

    // R1: 219 clocks rejected, 220 accepted
    mode = 2'b10;
    begin
      int v0;
      v0 = vld_cnt;
      send_break(11 * BDIV - 1);
      send_ivls(BDIV, BDIV);
      @(negedge clk);
      chk("R1 short break rejected", vld_cnt - v0, 0);
      chk("R1 short break no flag", int'(brk_flag), 0);
      @(posedge clk); #1;
      v0 = vld_cnt;
      send_break(11 * BDIV);
      send_ivls(BDIV, BDIV);
      @(negedge clk);
      chk("R1 exact break accepted", vld_cnt - v0, 1);
      @(posedge clk); #1;
      clear_all();
    end

    // R2: wait request accepts a short pulse once
    begin
      int v0;
      wfb = 1'b1; @(posedge clk); #1; wfb = 1'b0;
      v0 = vld_cnt;
      send_break(30);
      send_ivls(BDIV, BDIV);
      @(negedge clk);
      chk("R2 armed short break accepted", vld_cnt - v0, 1);
      chk("R2 divisor", last_div, BDIV);
      @(posedge clk); #1;
      clear_all();
      v0 = vld_cnt;
      send_break(30);
      send_ivls(BDIV, BDIV);
      @(negedge clk);
      chk("R2 request used up", vld_cnt - v0, 0);
      @(posedge clk); #1;
    end

    // R7: flag stays low mid-sync
    send_break(13 * BDIV);
    hold(1'b0, BDIV); hold(1'b1, BDIV); hold(1'b0, BDIV); hold(1'b1, BDIV);
    @(negedge clk);
    chk("R7 no flag mid-sync", int'(brk_flag), 0);
    @(posedge clk); #1;
    hold(1'b0, BDIV); hold(1'b1, BDIV); hold(1'b0, BDIV); hold(1'b1, BDIV);
    hold(1'b0, BDIV); hold(1'b1, 3 * BDIV);
    @(negedge clk);
    chk("R7 flag after sync", int'(brk_flag), 1);
    @(posedge clk); #1;

    // R8: data byte clears flag, then write clear
    drcv = 1'b1; @(posedge clk); #1; drcv = 1'b0;
    @(negedge clk);
    chk("R8 cleared by data byte", int'(brk_flag), 0);
    @(posedge clk); #1;
    good_sync();
    @(negedge clk);
    chk("R8 flag set again", int'(brk_flag), 1);
    @(posedge clk); #1;
    bclr = 1'b1; @(posedge clk); #1; bclr = 1'b0;
    @(negedge clk);
    chk("R8 cleared by write", int'(brk_flag), 0);
    @(posedge clk); #1;

    // R9: leaving auto mode drops the flag; plain modes detect nothing
    good_sync();
    mode = 2'b00;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R9 flag dropped in plain mode", int'(brk_flag), 0);
    @(posedge clk); #1;
    for (int m = 0; m < 2; m++) begin
      int v0;
      mode = 2'(m);
      v0 = vld_cnt;
      good_sync();
      @(negedge clk);
      chk($sformatf("R9 mode %0d no strobe", m), vld_cnt - v0, 0);
      chk($sformatf("R9 mode %0d no flag", m), int'(brk_flag), 0);
      @(posedge clk); #1;
    end

    // R5 / R10: wrong sync value, then error lockout
    mode = 2'b10;
    begin
      int v0;
      v0 = vld_cnt;
      send_break(13 * BDIV);
      send_byte(8'h33, BDIV);
      repeat (1700) @(posedge clk);
      @(negedge clk);
      chk("R5 value 0x33 raises error", int'(sync_err), 1);
      chk("R5 value 0x33 no strobe", vld_cnt - v0, 0);
      @(posedge clk); #1;
      good_sync();
      @(negedge clk);
      chk("R10 locked out, no strobe", vld_cnt - v0, 0);
      chk("R10 error held", int'(sync_err), 1);
      @(posedge clk); #1;
      eclr = 1'b1; @(posedge clk); #1; eclr = 1'b0;
      @(negedge clk);
      chk("R10 error cleared", int'(sync_err), 0);
      @(posedge clk); #1;
      good_sync();
      @(negedge clk);
      chk("R10 re-armed", vld_cnt - v0, 1);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule